// File: doc/BRIEF.md
# Boot Configuration Record Sequencer

This block runs the configuration stage that follows reset. It takes a stream of 32-bit words, two per record. The first word of a record says either "write to this address" or "perform this control action". The second word carries the payload. A write record produces one single-beat write on a 36-bit write-request port. A control record does one of three things:

- It ends the stage.
- It waits a number of clocks given by the payload.
- It captures a pending update for the serial-interface mode register. Only the clock-related fields are kept, and the update is applied when the stage ends.

Records enter through a valid/ready port. A word is taken on any rising edge where both `rec_valid` and `rec_ready` are high. The sequencer holds `rec_ready` low in four cases: while a write waits for acknowledgment, while a delay runs, after the stage has ended, and after an error. The source must keep a word and `rec_valid` steady until the word is taken. On the write port, `wr_valid` holds the address and data steady until the rising edge where `wr_ready` is high. Errors are reported on `err`, and that flag stays set. A malformed control word stops the stage with no further writes.

Top module: `boot_cfg_seq`

## Requirements
- R1: After reset is released, `rec_ready` is 1 and `wr_valid`, `done` and `err` are 0.
- R2: A first word with bit 0 clear is a write record. After its second word is taken, exactly one write is issued. Its address is `{4'b0, word[31:2], 2'b00}`, so bit 1 of the first word has no effect. Its data is the second word.
- R3: While `wr_valid` is 1 and `wr_ready` is 0, the following hold. `wr_valid` stays 1 in the next cycle. `wr_addr` and `wr_data` do not change. `rec_ready` is 0.
- R4: A first word with bit 0 set is a control word. Bit 31 means end, bit 30 means delay and bit 29 means mode change. The word is legal only if bits 28:1 are all zero and exactly one of bits 31:29 is set.
- R5: An illegal control word is flagged in the cycle after it is taken, and `err` then stays 1. After that, `rec_ready` stays 0, no write is issued and `done` never rises.
- R6: For a delay record with payload N, `rec_ready` is 0 for exactly 8·N cycles after the payload is taken. For N = 0 there is no wait at all.
- R7: A mode-change record issues no write. It replaces any earlier pending mode value, so the last such record wins.
- R8: An end record with a mode change pending causes one write to `MODE_ADDR`. Its data is `(mode_cur & ~MODE_MASK) | (pending & MODE_MASK)`. The default mask is 32'h0000_100F, which covers the prescale field in bits 3:0 and the divide-by-16 bit at bit 12. `done` rises in the cycle after that write's handshake.
- R9: An end record with no mode change pending issues no write. `done` is 1 in the cycle after its payload is taken.
- R10: Once `done` is 1 it stays 1, `rec_ready` stays 0 and no further write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Record word offered |
| rec_data | input | 32 | Record word |
| rec_ready | output | 1 | Sequencer takes a word this cycle |
| wr_valid | output | 1 | Write request pending |
| wr_addr | output | 36 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accepted on this edge |
| mode_cur | input | 32 | Present value of the serial mode register |
| done | output | 1 | Configuration stage finished |
| err | output | 1 | Malformed control word seen (sticky) |

## Verification
The assertions check four properties on every cycle:

- the write port holds steady under back-pressure;
- write addresses are word aligned with the top four bits clear;
- `rec_ready` is never high while a write is pending or after the stage has stopped;
- `done` and `err` stay set once raised.

Only the directed scenarios can show the rest:

- the decoded addresses and data;
- the exact 8·N-cycle delay, including N = 0;
- the last-wins merge of the mode-register update;
- the one-cycle spacing between the final write and `done`;
- which control words count as illegal.

// File: rtl/boot_cfg_pkg.sv
`timescale 1ns/1ps
package boot_cfg_pkg;
  typedef enum logic [1:0] {
    K_WR  = 2'd0,
    K_END = 2'd1,
    K_DLY = 2'd2,
    K_FRQ = 2'd3
  } rec_kind_e;

  typedef enum logic [2:0] {
    ST_CTRL  = 3'd0,
    ST_DATA  = 3'd1,
    ST_WRITE = 3'd2,
    ST_DELAY = 3'd3,
    ST_MODE  = 3'd4,
    ST_DONE  = 3'd5,
    ST_ERR   = 3'd6
  } seq_state_e;
endpackage

// File: rtl/boot_cfg_decode.sv
`timescale 1ns/1ps
module boot_cfg_decode
  import boot_cfg_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 36
) (
  input  logic [DW-1:0] word,
  output rec_kind_e     kind,
  output logic          illegal,
  output logic [AW-1:0] addr
);
  localparam int PADW = AW - DW;

  logic [2:0] sel;
  logic       resv_clear;
  logic       one_sel;

  assign sel        = word[DW-1:DW-3];
  assign resv_clear = (word[DW-4:1] == '0);
  assign one_sel    = (sel == 3'b100) || (sel == 3'b010) || (sel == 3'b001);
  assign illegal    = word[0] && !(resv_clear && one_sel);
  assign addr       = {{PADW{1'b0}}, word[DW-1:2], 2'b00};

  always_comb begin
    if (!word[0])     kind = K_WR;
    else if (sel[2])  kind = K_END;
    else if (sel[1])  kind = K_DLY;
    else              kind = K_FRQ;
  end
endmodule

// File: rtl/boot_cfg_timer.sv
`timescale 1ns/1ps
module boot_cfg_timer #(
  parameter int CW = 32,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] count,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pre_q;

  assign expire = (cnt_q == CW'(1)) && (pre_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (load) begin
      cnt_q <= count;
      pre_q <= '0;
    end else if (cnt_q != '0) begin
      pre_q <= pre_q + 1'b1;
      if (pre_q == '1) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/boot_cfg_seq.sv
`timescale 1ns/1ps
module boot_cfg_seq
  import boot_cfg_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          AW        = 36,
  parameter int          PW        = 3,
  parameter logic [35:0] MODE_ADDR = 36'h0_0000_F000,
  parameter logic [31:0] MODE_MASK = 32'h0000_100F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_valid,
  input  logic [DW-1:0] rec_data,
  output logic          rec_ready,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  input  logic [DW-1:0] mode_cur,
  output logic          done,
  output logic          err
);
  seq_state_e    st_q;
  rec_kind_e     kind_q;
  rec_kind_e     dec_kind;
  logic          dec_illegal;
  logic [AW-1:0] dec_addr;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          pend_q;
  logic [DW-1:0] pend_val_q;
  logic          take;
  logic          tmr_load;
  logic          tmr_expire;

  boot_cfg_decode #(.DW(DW), .AW(AW)) u_dec (
    .word    (rec_data),
    .kind    (dec_kind),
    .illegal (dec_illegal),
    .addr    (dec_addr)
  );

  assign rec_ready = (st_q == ST_CTRL) || (st_q == ST_DATA);
  assign take      = rec_valid && rec_ready;
  assign wr_valid  = (st_q == ST_WRITE) || (st_q == ST_MODE);
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
  assign done      = (st_q == ST_DONE);
  assign err       = (st_q == ST_ERR);
  assign tmr_load  = take && (st_q == ST_DATA) && (kind_q == K_DLY)
                     && (rec_data != '0);

  boot_cfg_timer #(.CW(DW), .PW(PW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .count  (rec_data),
    .expire (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_CTRL;
      kind_q     <= K_WR;
      addr_q     <= '0;
      data_q     <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else begin
      case (st_q)
        ST_CTRL: if (take) begin
          kind_q <= dec_kind;
          addr_q <= dec_addr;
          st_q   <= dec_illegal ? ST_ERR : ST_DATA;
        end
        ST_DATA: if (take) begin
          case (kind_q)
            K_WR: begin
              data_q <= rec_data;
              st_q   <= ST_WRITE;
            end
            K_DLY: st_q <= (rec_data == '0) ? ST_CTRL : ST_DELAY;
            K_FRQ: begin
              pend_q     <= 1'b1;
              pend_val_q <= rec_data & MODE_MASK;
              st_q       <= ST_CTRL;
            end
            default: begin
              if (pend_q) begin
                addr_q <= MODE_ADDR;
                data_q <= (mode_cur & ~MODE_MASK) | pend_val_q;
                st_q   <= ST_MODE;
              end else begin
                st_q <= ST_DONE;
              end
            end
          endcase
        end
        ST_WRITE: if (wr_ready)   st_q <= ST_CTRL;
        ST_DELAY: if (tmr_expire) st_q <= ST_CTRL;
        ST_MODE:  if (wr_ready)   st_q <= ST_DONE;
        default:  st_q <= st_q;
      endcase
    end
  end
endmodule

// File: rtl/boot_cfg_seq_chk.sv
`timescale 1ns/1ps
module boot_cfg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rec_ready,
  input logic        wr_valid,
  input logic [35:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        wr_ready,
  input logic        done,
  input logic        err
);
  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R3
  wr_blocks_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rec_ready);

  // R2
  wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00 && wr_addr[35:32] == 4'h0));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !done));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!rec_ready && !wr_valid));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rec_ready && !wr_valid));
endmodule

bind boot_cfg_seq boot_cfg_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rec_ready (rec_ready),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_ready  (wr_ready),
  .done      (done),
  .err       (err)
);

// File: tb/test_boot_cfg_seq.sv
`timescale 1ns/1ps
module test_boot_cfg_seq;
  localparam logic [35:0] MADDR = 36'h0_0000_F000;
  localparam logic [31:0] MMASK = 32'h0000_100F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic [31:0] rec_data = '0;
  logic        rec_ready;
  logic        wr_valid;
  logic [35:0] wr_addr;
  logic [31:0] wr_data;
  logic        wr_ready = 1'b0;
  logic [31:0] mode_cur = '0;
  logic        done;
  logic        err;

  int nchk = 0;
  int nfail = 0;
  int nlog = 0;
  int lat = 0;
  int lcnt = 0;
  bit seen = 0;
  logic [35:0] first_a;
  logic [31:0] first_d;
  logic [35:0] cap_a;
  logic [31:0] cap_d;
  logic [35:0] log_a [0:15];
  logic [31:0] log_d [0:15];

  always #2.5 clk = ~clk;

  boot_cfg_seq i_boot_cfg_seq (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
    .rec_ready(rec_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .mode_cur(mode_cur),
    .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write-port responder with programmable latency
  always @(negedge clk) begin
    if (wr_ready) begin
      if (nlog < 16) begin
        log_a[nlog] = cap_a;
        log_d[nlog] = cap_d;
      end
      nlog++;
      wr_ready = 1'b0;
      lcnt = 0;
      seen = 0;
    end else if (wr_valid) begin
      if (!seen) begin
        seen = 1;
        first_a = wr_addr;
        first_d = wr_data;
      end
      if (lcnt >= lat) begin
        chk(wr_addr == first_a && wr_data == first_d, "R3 hold",
            {28'h0, wr_addr}, {28'h0, first_a});
        chk(!rec_ready, "R3 rec_ready low", {63'h0, rec_ready}, 64'h0);
        cap_a = wr_addr;
        cap_d = wr_data;
        wr_ready = 1'b1;
      end else begin
        lcnt++;
      end
    end
  end

  task automatic do_reset();
    rec_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    nlog = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    rec_valid = 1'b1;
    rec_data = w;
    while (!rec_ready) @(negedge clk);
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic send_rec(input logic [31:0] a, input logic [31:0] d);
    send_word(a);
    send_word(d);
  endtask

  task automatic wait_logs(input int n);
    for (int i = 0; i < 100 && nlog < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(rec_ready == 1'b1, "R1 rec_ready", {63'h0, rec_ready}, 64'h1);
    chk({wr_valid, done, err} == 3'b000, "R1 outputs idle",
        {61'h0, wr_valid, done, err}, 64'h0);
  endtask

  task automatic t_writes();
    do_reset();
    lat = 2;
    send_rec(32'h1234_5670, 32'hDEAD_BEEF);
    send_rec(32'hFFFF_FFFE, 32'h1357_9BDF);
    wait_logs(2);
    chk(nlog == 2, "R2 write count", 64'(nlog), 64'd2);
    chk(log_a[0] == 36'h0_1234_5670 && log_d[0] == 32'hDEAD_BEEF, "R2 first write",
        {log_d[0], log_a[0][31:0]}, {32'hDEAD_BEEF, 32'h1234_5670});
    chk(log_a[1] == 36'h0_FFFF_FFFC && log_d[1] == 32'h1357_9BDF, "R2 bit1 ignored",
        {28'h0, log_a[1]}, {28'h0, 36'h0_FFFF_FFFC});
    chk(done == 1'b0, "R9 not done before end", {63'h0, done}, 64'h0);
    send_rec(32'h8000_0001, 32'h0);
    chk(done == 1'b1 && nlog == 2, "R9 done without write",
        {31'h0, done, 32'(nlog)}, {31'h0, 1'b1, 32'd2});
    // R10: further words are refused
    @(negedge clk);
    rec_valid = 1'b1;
    rec_data = 32'h0000_0100;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 5)
        chk(!rec_ready && !wr_valid && done && nlog == 2, "R10 frozen after done",
            {61'h0, rec_ready, wr_valid, done}, 64'h1);
    end
    rec_valid = 1'b0;
  endtask

  task automatic t_delay(input logic [31:0] n);
    int c;
    do_reset();
    send_rec(32'h4000_0001, n);
    c = 0;
    while (!rec_ready && c < 1000) begin
      c++;
      @(negedge clk);
    end
    chk(c == int'(n) * 8, "R6 delay length", 64'(c), 64'(int'(n) * 8));
    chk(nlog == 0 && !err, "R6 delay issues nothing", 64'(nlog), 64'h0);
  endtask

  task automatic t_mode();
    logic [31:0] expd;
    bit got;
    do_reset();
    lat = 1;
    mode_cur = 32'hA5A5_A5A5;
    send_rec(32'h2000_0001, 32'h1111_1111);
    send_rec(32'h2000_0001, 32'h5A5A_F00F);
    chk(nlog == 0 && !wr_valid, "R7 no write on mode record", 64'(nlog), 64'h0);
    expd = (32'hA5A5_A5A5 & ~MMASK) | (32'h5A5A_F00F & MMASK);
    send_word(32'h8000_0001);
    @(negedge clk);
    rec_valid = 1'b1;
    rec_data = 32'h0;
    while (!rec_ready) @(negedge clk);
    got = 0;
    for (int i = 0; i < 50 && !got; i++) begin
      @(negedge clk);
      rec_valid = 1'b0;
      #1;
      if (nlog == 1) begin
        got = 1;
        chk(done == 1'b1, "R8 done after mode write", {63'h0, done}, 64'h1);
      end else if (done) begin
        chk(1'b0, "R8 done before mode write", 64'h1, 64'h0);
      end
    end
    chk(got, "R8 mode write seen", 64'(nlog), 64'h1);
    chk(log_a[0] == MADDR && log_d[0] == expd, "R8 merged mode value",
        {log_d[0], log_a[0][31:0]}, {expd, MADDR[31:0]});
  endtask

  task automatic t_illegal(input logic [31:0] w);
    int n0;
    do_reset();
    lat = 0;
    send_rec(32'h0000_0100, 32'h0000_0001);
    send_word(w);
    n0 = nlog;
    chk(err && !rec_ready && !done, "R5 error flagged",
        {61'h0, err, rec_ready, done}, 64'h4);
    @(negedge clk);
    rec_valid = 1'b1;
    rec_data = 32'h0000_0200;
    repeat (6) @(negedge clk);
    chk(err && !wr_valid && nlog == n0 && !done, "R5 halted after error",
        64'(nlog), 64'(n0));
    rec_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_writes();
    t_delay(32'd3);
    t_delay(32'd0);
    t_delay(32'd1);
    t_mode();
    // R4 illegal encodings
    t_illegal(32'h0000_0001);
    t_illegal(32'hE000_0001);
    t_illegal(32'h0000_0011);
    t_illegal(32'h8000_0003);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule